// File: doc/BRIEF.md
# ALU Status Flag Register

This block sits beside a 16-bit ALU and turns each ALU result into a packed flags word. When the ALU presents a completed operation, the block takes the two operands, the result, the ALU's carry output and the operation class. From these it computes six status flags: carry, parity, nibble carry, zero, sign and overflow. It holds them until the next operation. It also holds three control flags: single-step trap enable, interrupt enable and string direction. No ALU operation changes these three. Only their own write strobes do.

The operation class is add, subtract, logic or shift/rotate. A size select chooses between 16-bit and 8-bit results. In 8-bit mode the sign, zero and overflow flags come from the low byte. The flags word has a fixed layout that other logic decodes. Each flag is also driven out on its own pin. All state is registered. A flag changes on the rising clock edge at which its update or write strobe is sampled, and it is visible from then on.

Top module: `alu_flag_reg`

## Requirements
- R1: An active-low asynchronous reset clears every flag, so flagWord reads 16'h0000.
- R2: The flagWord layout is carry at bit 0, parity at bit 2, nibble carry at bit 4, zero at bit 6, sign at bit 7, trap at bit 8, interrupt at bit 9, direction at bit 10 and overflow at bit 11. Every other bit reads 0. Each individual flag output equals its bit in flagWord.
- R3: On an operation with opValid high, the carry flag is set as follows. For add (opClass 2'b00) it takes carryOut, the carry out of the most significant bit of the selected size. For subtract (2'b01) it takes carryOut as the borrow. For shift/rotate (2'b11) it takes carryOut as the last bit shifted out. For logic (2'b10) it is cleared and carryOut is ignored.
- R4: For add, overflow is set when both operands have the same sign bit and the result's sign bit differs from it. For subtract, overflow is set when the operands' sign bits differ and the result's sign bit differs from operandA's. Logic clears overflow. Shift leaves overflow unchanged.
- R5: The sign flag is the result's most significant bit. The zero flag is 1 when the result is all zeros. In 16-bit mode (byteMode 0) both use all 16 bits.
- R6: The parity flag is 1 when result[7:0] holds an even number of ones, in either size.
- R7: For add and subtract, the nibble carry flag is operandA[4] ^ operandB[4] ^ result[4], the carry or borrow from bit 3 into bit 4. Logic clears it. Shift leaves it unchanged.
- R8: In 8-bit mode (byteMode 1), sign and overflow use bit 7 of the operands and result, and zero tests only result[7:0].
- R9: ctlWrEn bit 0, 1 and 2 load ctlWrData bit 0, 1 and 2 into trap, interrupt and direction respectively. A control flag whose enable is low keeps its value, whatever operations run.
- R10: While opValid is low the six status flags keep their values. An operation and a control write in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | ALU result is valid; update the status flags |
| opClass | input | 2 | 00 add, 01 subtract, 10 logic, 11 shift/rotate |
| byteMode | input | 1 | 1 selects 8-bit result size |
| operandA | input | 16 | First operand (minuend for subtract) |
| operandB | input | 16 | Second operand (subtrahend for subtract) |
| result | input | 16 | ALU result |
| carryOut | input | 1 | ALU carry/borrow out, or last bit shifted out |
| ctlWrEn | input | 3 | Per-flag write enables: 0 trap, 1 interrupt, 2 direction |
| ctlWrData | input | 3 | Values written to the enabled control flags |
| flagWord | output | 16 | Packed flags word |
| carryFlag | output | 1 | Carry flag |
| parityFlag | output | 1 | Even parity of the result's low byte |
| auxFlag | output | 1 | Nibble carry flag |
| zeroFlag | output | 1 | Zero flag |
| signFlag | output | 1 | Sign flag |
| trapFlag | output | 1 | Single-step trap enable |
| intFlag | output | 1 | Interrupt enable |
| dirFlag | output | 1 | String direction |
| ovfFlag | output | 1 | Signed overflow flag |

## Verification
The bench drives byte-mode results whose bit 7 and bit 15 disagree and whose low byte is zero while the high byte is not. A design that tests the wrong bit for sign, zero or overflow then reports the wrong value. It runs a subtract whose operands differ in sign, which catches a design that reuses the add overflow rule. It runs a logic operation with carryOut high, which catches a design that passes the carry through. It runs a shift after a step that set overflow and nibble carry, which catches a design that clears those two on a shift. It also writes control flags one at a time, and together with an operation in the same cycle. A design that ties the strobes together or lets an ALU update touch the control bits then shows the wrong flagWord.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

  localparam int FLAG_W   = 16;
  localparam int NUM_CTL  = 3;
  localparam int NIBBLE_W = 4;

  // fixed layout decoded by neighbours
  localparam int POS_CARRY  = 0;
  localparam int POS_PARITY = 2;
  localparam int POS_AUX    = 4;
  localparam int POS_ZERO   = 6;
  localparam int POS_SIGN   = 7;
  localparam int POS_TRAP   = 8;
  localparam int POS_INT    = 9;
  localparam int POS_DIR    = 10;
  localparam int POS_OVF    = 11;

  localparam int CTL_TRAP = 0;
  localparam int CTL_INT  = 1;
  localparam int CTL_DIR  = 2;

  typedef enum logic [1:0] {
    OP_ADD   = 2'b00,
    OP_SUB   = 2'b01,
    OP_LOGIC = 2'b10,
    OP_SHIFT = 2'b11
  } opClass_e;

  typedef struct packed {
    logic                 updStatus;
    logic                 isSub;
    logic                 isLogic;
    logic                 isShift;
    logic                 byteSel;
    logic [NUM_CTL-1:0]   ctlWr;
    logic [NUM_CTL-1:0]   ctlVal;
  } flagStrobe_t;

  function automatic int ctlPos(input int idx);
    case (idx)
      CTL_TRAP: ctlPos = POS_TRAP;
      CTL_INT:  ctlPos = POS_INT;
      default:  ctlPos = POS_DIR;
    endcase
  endfunction

endpackage

// File: rtl/alu_flag_ctrl.sv
module alu_flag_ctrl
  import alu_flag_pkg::*;
(
  input  logic               opValid,
  input  logic [1:0]         opClass,
  input  logic               byteMode,
  input  logic [NUM_CTL-1:0] ctlWrEn,
  input  logic [NUM_CTL-1:0] ctlWrData,
  output flagStrobe_t        strobe
);

  opClass_e cls;
  assign cls = opClass_e'(opClass);

  always_comb begin
    strobe           = '0;
    strobe.updStatus = opValid;
    strobe.byteSel   = byteMode;
    unique case (cls)
      OP_SUB:   strobe.isSub   = 1'b1;
      OP_LOGIC: strobe.isLogic = 1'b1;
      OP_SHIFT: strobe.isShift = 1'b1;
      default:  ;
    endcase
    strobe.ctlWr  = ctlWrEn;
    strobe.ctlVal = ctlWrData;
  end

endmodule

// File: rtl/alu_flag_dp.sv
module alu_flag_dp
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  flagStrobe_t       strobe,
  input  logic [DATA_W-1:0] operandA,
  input  logic [DATA_W-1:0] operandB,
  input  logic [DATA_W-1:0] result,
  input  logic              carryOut,
  output logic [FLAG_W-1:0] flagWord
);

  localparam int WORD_MSB = DATA_W - 1;
  localparam int BYTE_MSB = BYTE_W - 1;

  // only a few operand bits matter; the rest are named to mark them as unused
  logic unusedOperandBits;
  assign unusedOperandBits = ^{operandA, operandB};

  logic signA, signB, signR;
  logic zeroNext, parityNext, auxNext, ovfArith, carryNext, ovfNext, auxSel;

  always_comb begin
    signA = strobe.byteSel ? operandA[BYTE_MSB] : operandA[WORD_MSB];
    signB = strobe.byteSel ? operandB[BYTE_MSB] : operandB[WORD_MSB];
    signR = strobe.byteSel ? result[BYTE_MSB]   : result[WORD_MSB];
  end

  assign zeroNext   = strobe.byteSel ? (result[BYTE_MSB:0] == '0) : (result == '0);
  assign parityNext = ~^result[BYTE_MSB:0];
  assign auxNext    = operandA[NIBBLE_W] ^ operandB[NIBBLE_W] ^ result[NIBBLE_W];

  // add: like signs in, other sign out; sub: unlike signs in, minuend sign lost
  assign ovfArith = strobe.isSub ? ((signA != signB) && (signR != signA))
                                 : ((signA == signB) && (signR != signA));

  logic carryQ, parityQ, auxQ, zeroQ, signQ, ovfQ;

  always_comb begin
    carryNext = carryOut;
    ovfNext   = ovfArith;
    auxSel    = auxNext;
    if (strobe.isLogic) begin
      carryNext = 1'b0;
      ovfNext   = 1'b0;
      auxSel    = 1'b0;
    end else if (strobe.isShift) begin
      ovfNext   = ovfQ;
      auxSel    = auxQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      carryQ  <= 1'b0;
      parityQ <= 1'b0;
      auxQ    <= 1'b0;
      zeroQ   <= 1'b0;
      signQ   <= 1'b0;
      ovfQ    <= 1'b0;
    end else if (strobe.updStatus) begin
      carryQ  <= carryNext;
      parityQ <= parityNext;
      auxQ    <= auxSel;
      zeroQ   <= zeroNext;
      signQ   <= signR;
      ovfQ    <= ovfNext;
    end
  end

  logic [NUM_CTL-1:0] ctlQ;

  for (genvar gi = 0; gi < NUM_CTL; gi++) begin : g_ctl
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        ctlQ[gi] <= 1'b0;
      else if (strobe.ctlWr[gi])
        ctlQ[gi] <= strobe.ctlVal[gi];
    end
  end

  always_comb begin
    flagWord             = '0;
    flagWord[POS_CARRY]  = carryQ;
    flagWord[POS_PARITY] = parityQ;
    flagWord[POS_AUX]    = auxQ;
    flagWord[POS_ZERO]   = zeroQ;
    flagWord[POS_SIGN]   = signQ;
    flagWord[POS_OVF]    = ovfQ;
    for (int i = 0; i < NUM_CTL; i++)
      flagWord[ctlPos(i)] = ctlQ[i];
  end

endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [1:0]        opClass,
  input  logic              byteMode,
  input  logic [DATA_W-1:0] operandA,
  input  logic [DATA_W-1:0] operandB,
  input  logic [DATA_W-1:0] result,
  input  logic              carryOut,
  input  logic [2:0]        ctlWrEn,
  input  logic [2:0]        ctlWrData,
  output logic [15:0]       flagWord,
  output logic              carryFlag,
  output logic              parityFlag,
  output logic              auxFlag,
  output logic              zeroFlag,
  output logic              signFlag,
  output logic              trapFlag,
  output logic              intFlag,
  output logic              dirFlag,
  output logic              ovfFlag
);

  flagStrobe_t strobe;

  alu_flag_ctrl u_ctrl (
    .opValid   (opValid),
    .opClass   (opClass),
    .byteMode  (byteMode),
    .ctlWrEn   (ctlWrEn),
    .ctlWrData (ctlWrData),
    .strobe    (strobe)
  );

  alu_flag_dp #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .operandA (operandA),
    .operandB (operandB),
    .result   (result),
    .carryOut (carryOut),
    .flagWord (flagWord)
  );

  assign carryFlag  = flagWord[POS_CARRY];
  assign parityFlag = flagWord[POS_PARITY];
  assign auxFlag    = flagWord[POS_AUX];
  assign zeroFlag   = flagWord[POS_ZERO];
  assign signFlag   = flagWord[POS_SIGN];
  assign trapFlag   = flagWord[POS_TRAP];
  assign intFlag    = flagWord[POS_INT];
  assign dirFlag    = flagWord[POS_DIR];
  assign ovfFlag    = flagWord[POS_OVF];

endmodule

// File: rtl/alu_flag_reg_checker.sv
module alu_flag_reg_checker #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [1:0]        opClass,
  input logic              byteMode,
  input logic [DATA_W-1:0] operandA,
  input logic [DATA_W-1:0] operandB,
  input logic [DATA_W-1:0] result,
  input logic              carryOut,
  input logic [2:0]        ctlWrEn,
  input logic [2:0]        ctlWrData,
  input logic [15:0]       flagWord,
  input logic              carryFlag,
  input logic              parityFlag,
  input logic              auxFlag,
  input logic              zeroFlag,
  input logic              signFlag,
  input logic              trapFlag,
  input logic              intFlag,
  input logic              dirFlag,
  input logic              ovfFlag
);

  localparam logic [15:0] LIVE_MASK = 16'h0FD5;

  logic unusedInputs;
  assign unusedInputs = ^{operandA, operandB, carryOut, signFlag, intFlag, dirFlag};

  p_reset_clear_r1: assert property (@(posedge clk) !rstN |=> flagWord == 16'h0000)
    else $error("reset did not clear flags");

  p_dead_bits_r2: assert property (@(posedge clk) disable iff (!rstN)
    (flagWord & ~LIVE_MASK) == 16'h0000)
    else $error("unused flag bit set");

  p_logic_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opClass == 2'b10) |=> (!carryFlag && !ovfFlag && !auxFlag))
    else $error("logic op left C/O/A set");

  p_shift_keep_ovf_r4: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opClass == 2'b11) |=> ($stable(ovfFlag) && $stable(auxFlag)))
    else $error("shift changed O or A");

  p_zero_word_r5: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !byteMode) |=> (zeroFlag == ($past(result) == '0)))
    else $error("16-bit zero flag wrong");

  p_parity_r6: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> (parityFlag == ~^$past(result[BYTE_W-1:0])))
    else $error("parity flag wrong");

  p_zero_byte_r8: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && byteMode) |=> (zeroFlag == ($past(result[BYTE_W-1:0]) == '0)))
    else $error("8-bit zero flag wrong");

  p_ctl_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWrEn == 3'b000) |=> $stable(flagWord[10:8]))
    else $error("control flag changed without write");

  p_trap_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctlWrEn[0] |=> (trapFlag == $past(ctlWrData[0])))
    else $error("trap write lost");

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> ($stable(flagWord[7:0]) && $stable(flagWord[11])))
    else $error("status flag changed while idle");

endmodule

bind alu_flag_reg alu_flag_reg_checker #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/alu_flag_reg_bench.sv
module alu_flag_reg_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 11;

  typedef struct packed {
    logic [1:0]  cls;
    logic        bm;
    logic [15:0] a;
    logic [15:0] b;
    logic [15:0] r;
    logic        co;
    logic [15:0] exp;
  } vec_t;

  // run in order from reset; shift rows rely on O and A of the row before
  localparam vec_t VECS [N_VEC] = '{
    '{2'b00, 1'b0, 16'h0001, 16'h0001, 16'h0002, 1'b0, 16'h0000},
    '{2'b00, 1'b0, 16'h7FFF, 16'h0001, 16'h8000, 1'b0, 16'h0894},
    '{2'b00, 1'b0, 16'hFFFF, 16'h0001, 16'h0000, 1'b1, 16'h0055},
    '{2'b01, 1'b0, 16'h0000, 16'h0001, 16'hFFFF, 1'b1, 16'h0095},
    '{2'b01, 1'b0, 16'h8000, 16'h0001, 16'h7FFF, 1'b0, 16'h0814},
    '{2'b11, 1'b0, 16'h8001, 16'h0001, 16'h0002, 1'b1, 16'h0811},
    '{2'b10, 1'b0, 16'h00F0, 16'h0F0F, 16'h0000, 1'b1, 16'h0044},
    '{2'b00, 1'b1, 16'h107F, 16'h2001, 16'h3080, 1'b0, 16'h0890},
    '{2'b00, 1'b1, 16'h12FF, 16'h0001, 16'h1300, 1'b1, 16'h0055},
    '{2'b01, 1'b1, 16'h0080, 16'h0001, 16'h007F, 1'b0, 16'h0810},
    '{2'b11, 1'b1, 16'h0081, 16'h0001, 16'h00C0, 1'b1, 16'h0895}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [1:0]  opClass = 2'b00;
  logic        byteMode = 1'b0;
  logic [15:0] operandA = '0, operandB = '0, result = '0;
  logic        carryOut = 1'b0;
  logic [2:0]  ctlWrEn = '0, ctlWrData = '0;
  logic [15:0] flagWord;
  logic carryFlag, parityFlag, auxFlag, zeroFlag, signFlag;
  logic trapFlag, intFlag, dirFlag, ovfFlag;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_flag_reg u_alu_flag_reg (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opClass(opClass),
    .byteMode(byteMode), .operandA(operandA), .operandB(operandB),
    .result(result), .carryOut(carryOut), .ctlWrEn(ctlWrEn),
    .ctlWrData(ctlWrData), .flagWord(flagWord), .carryFlag(carryFlag),
    .parityFlag(parityFlag), .auxFlag(auxFlag), .zeroFlag(zeroFlag),
    .signFlag(signFlag), .trapFlag(trapFlag), .intFlag(intFlag),
    .dirFlag(dirFlag), .ovfFlag(ovfFlag)
  );

  task automatic checkWord(input string req, input logic [15:0] exp);
    checks++;
    if (flagWord !== exp) begin
      errors++;
      $display("FAIL %s: flagWord actual %h expected %h", req, flagWord, exp);
    end
  endtask

  // R2: individual pins must match their layout positions
  task automatic checkPins(input logic [15:0] exp);
    logic [8:0] act, want;
    act  = {ovfFlag, dirFlag, intFlag, trapFlag, signFlag, zeroFlag, auxFlag, parityFlag, carryFlag};
    want = {exp[11], exp[10], exp[9], exp[8], exp[7], exp[6], exp[4], exp[2], exp[0]};
    checks++;
    if (act !== want) begin
      errors++;
      $display("FAIL R2 pins: actual %b expected %b", act, want);
    end
  endtask

  task automatic step(input logic v, input logic [1:0] cls, input logic bm,
                      input logic [15:0] a, input logic [15:0] b, input logic [15:0] r,
                      input logic co, input logic [2:0] en, input logic [2:0] dat);
    @(negedge clk);
    opValid = v; opClass = cls; byteMode = bm;
    operandA = a; operandB = b; result = r; carryOut = co;
    ctlWrEn = en; ctlWrData = dat;
    @(negedge clk);
    opValid = 1'b0; ctlWrEn = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checkWord("R1 reset", 16'h0000);
    rstN = 1'b1;

    // R3 R4 R5 R6 R7 R8: table of operations
    for (int i = 0; i < N_VEC; i++) begin
      step(1'b1, VECS[i].cls, VECS[i].bm, VECS[i].a, VECS[i].b, VECS[i].r,
           VECS[i].co, 3'b000, 3'b000);
      checks++;
      if (flagWord !== VECS[i].exp) begin
        errors++;
        $display("FAIL R3/R4/R5/R6/R7/R8 vector %0d: actual %h expected %h",
                 i, flagWord, VECS[i].exp);
      end
      checkPins(VECS[i].exp);
    end

    // R10: idle cycle with changed inputs keeps status
    step(1'b0, 2'b10, 1'b0, 16'h0, 16'h0, 16'h0000, 1'b0, 3'b000, 3'b000);
    checkWord("R10 idle hold", 16'h0895);

    // R9: write trap only, other data bits high
    step(1'b0, 2'b00, 1'b0, 16'h0, 16'h0, 16'h0, 1'b0, 3'b001, 3'b111);
    checkWord("R9 trap only", 16'h0995);

    // R9: operation without write keeps trap
    step(1'b1, 2'b10, 1'b0, 16'h0, 16'h0, 16'h0001, 1'b1, 3'b000, 3'b000);
    checkWord("R9 ctl held over op", 16'h0100);

    // R10: operation and control write together
    step(1'b1, 2'b00, 1'b0, 16'h0001, 16'h0001, 16'h0002, 1'b0, 3'b110, 3'b110);
    checkWord("R10 op plus write", 16'h0700);
    checkPins(16'h0700);

    // R9: clear interrupt only
    step(1'b0, 2'b00, 1'b0, 16'h0, 16'h0, 16'h0, 1'b0, 3'b010, 3'b000);
    checkWord("R9 clear int", 16'h0500);

    // R1: reset mid-run
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    checkWord("R1 mid-run reset", 16'h0000);
    rstN = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule